// File: doc/BRIEF.md
# Systolic Rule Matching Array

This block classifies a group of packet headers against a ruleset that arrives as a stream. It first takes headers from an upstream queue and parks one in each processing element of a linear chain. The chain fills until every element holds a header, or until the queue runs dry after at least one header has arrived. Rules then enter at the head of the chain and advance one element per cycle, so every occupied element sees the whole ruleset in order. Because each rule reaches the elements one after another, no rule bus has to be broadcast to all of them. Each element tests every rule against its header and keeps the action of the best rule that matched.

A rule carries one key and one mask bit per header field, a priority and an action. The ruleset ends with a beat that has the end flag set. When that beat has passed the last element, all per-element results are copied into a parallel-load shift register in one cycle. The results then leave one per cycle, under backpressure, in the order the headers arrived. After the last result the block accepts a new group of headers.

Top module: `rule_match_array`

## Requirements
- R1: A rule matches a header only when every field whose mask bit is 1 equals the header field. Field f occupies bits [f*FIELD_W +: FIELD_W] of both header and key, and its mask bit is ruleMask[f].
- R2: A field whose mask bit is 0 matches whatever its value. A rule whose mask is all zeros matches every header.
- R3: Among matching rules, the one with the numerically largest priority wins. When priorities are equal, the rule that came earlier in the stream wins.
- R4: A header that matched no rule gives resHit = 0 and resAction = DEFAULT_ACTION (0 by default). A header that matched gives resHit = 1 and the action of the winning rule.
- R5: hdrReady is high only in the load phase, and only while fewer than NUM_PE headers are held. Loading ends when the array is full, or when hdrValid is low after at least one header has been accepted.
- R6: ruleReady is low while headers are loading and while results drain. It also goes low from the cycle after the beat carrying ruleLast is accepted.
- R7: Each loaded header gives exactly one result, in header arrival order. Empty elements give none. After the last result has been accepted, resValid is low and hdrReady is high.
- R8: While resValid is high and resReady is low, resValid stays high and resHit and resAction stay unchanged.
- R9: Cycles with ruleValid low inside the rule stream do not change any result.
- R10: Every group starts with cleared per-element state, so results never carry over from an earlier group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header offered |
| hdrData | input | NUM_FIELDS*FIELD_W | Header fields, field 0 in the low bits |
| hdrReady | output | 1 | Header accepted on this edge when hdrValid is high |
| ruleValid | input | 1 | Rule beat offered |
| ruleKey | input | NUM_FIELDS*FIELD_W | Rule compare values, same layout as hdrData |
| ruleMask | input | NUM_FIELDS | Per-field compare enable (1 = compare) |
| rulePrio | input | PRIO_W | Rule priority, larger wins |
| ruleAction | input | ACT_W | Rule action |
| ruleLast | input | 1 | Marks the final rule of the set |
| ruleReady | output | 1 | Rule beat accepted on this edge when ruleValid is high |
| resValid | output | 1 | Result offered |
| resHit | output | 1 | Some rule matched this header |
| resAction | output | ACT_W | Winning action or DEFAULT_ACTION |
| resReady | input | 1 | Result taken on this edge when resValid is high |

## Verification
The assertions check the handshake rules on every cycle. A stalled result must hold its value, and no rule may be accepted after the end beat. A header is never taken while rules are being taken. The number of results delivered never exceeds the number of headers accepted, and a result with no hit always carries the default action. Which rule wins, priority ties, wildcard fields, result order, partial loads and clearing between groups cannot be seen cycle by cycle. Only the bench's scenarios show them, by comparing each result with a model of the ruleset under stalled and gapped streams.

// File: rtl/rule_match_pkg.sv
package rule_match_pkg;

  typedef enum logic [1:0] {
    PH_LOAD    = 2'd0,
    PH_RUN     = 2'd1,
    PH_CAPTURE = 2'd2,
    PH_DRAIN   = 2'd3
  } phase_t;

  typedef struct packed {
    logic hdrShift;
    logic ruleTake;
    logic ruleAdvance;
    logic capture;
    logic outShift;
  } strobe_t;

endpackage

// File: rtl/rule_match_pe.sv
module rule_match_pe #(
  parameter int NUM_FIELDS = 3,
  parameter int FIELD_W = 8,
  parameter int PRIO_W = 8,
  parameter int ACT_W = 8,
  parameter logic [ACT_W-1:0] DEFAULT_ACTION = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clearBest,
  input  logic occupied,
  input  logic [NUM_FIELDS*FIELD_W-1:0] hdr,
  input  logic ruleValid,
  input  logic [NUM_FIELDS*FIELD_W-1:0] ruleKey,
  input  logic [NUM_FIELDS-1:0] ruleMask,
  input  logic [PRIO_W-1:0] rulePrio,
  input  logic [ACT_W-1:0] ruleAction,
  output logic bestHit,
  output logic [ACT_W-1:0] bestAction
);

  logic [NUM_FIELDS-1:0] fieldOk;
  logic [PRIO_W-1:0] bestPrio;
  logic ruleHit;
  logic takeRule;

  // one comparator per field; a cleared mask bit turns it into a wildcard
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    assign fieldOk[f] = !ruleMask[f] ||
                        (ruleKey[f*FIELD_W +: FIELD_W] == hdr[f*FIELD_W +: FIELD_W]);
  end

  assign ruleHit  = ruleValid && occupied && (&fieldOk);
  // strict compare keeps the earlier rule on a priority tie
  assign takeRule = ruleHit && (!bestHit || (rulePrio > bestPrio));

  always_ff @(posedge clk) begin
    if (!rst_n || clearBest) begin
      bestHit    <= 1'b0;
      bestPrio   <= '0;
      bestAction <= DEFAULT_ACTION;
    end else if (takeRule) begin
      bestHit    <= 1'b1;
      bestPrio   <= rulePrio;
      bestAction <= ruleAction;
    end
  end

endmodule

// File: rtl/rule_match_ctrl.sv
module rule_match_ctrl
  import rule_match_pkg::*;
#(
  parameter int NUM_PE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hdrValid,
  output logic hdrReady,
  input  logic ruleValid,
  input  logic ruleLast,
  output logic ruleReady,
  input  logic topValid,
  input  logic resReady,
  input  logic lastAtEnd,
  output strobe_t stb
);

  localparam int CNT_W = $clog2(NUM_PE + 1);
  localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(NUM_PE);
  localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

  phase_t phase, phaseNext;
  logic [CNT_W-1:0] loadCount;
  logic [CNT_W-1:0] pending;
  logic lastTaken;
  logic resTaken;

  assign resTaken = topValid && resReady;

  always_comb begin
    stb       = '0;
    hdrReady  = 1'b0;
    ruleReady = 1'b0;
    phaseNext = phase;
    case (phase)
      PH_LOAD: begin
        hdrReady     = (loadCount != FULL_COUNT);
        stb.hdrShift = hdrValid && hdrReady;
        if (!hdrReady || ((loadCount != '0) && !hdrValid)) phaseNext = PH_RUN;
      end
      PH_RUN: begin
        ruleReady       = !lastTaken;
        stb.ruleTake    = ruleValid && ruleReady;
        stb.ruleAdvance = 1'b1;
        if (lastAtEnd) phaseNext = PH_CAPTURE;
      end
      PH_CAPTURE: begin
        stb.capture = 1'b1;
        phaseNext   = PH_DRAIN;
      end
      PH_DRAIN: begin
        // empty slots at the top leave without a handshake
        stb.outShift = !topValid || resReady;
        if (resTaken && (pending == ONE_LEFT)) phaseNext = PH_LOAD;
      end
      default: phaseNext = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_LOAD;
      loadCount <= '0;
      pending   <= '0;
      lastTaken <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (stb.hdrShift) loadCount <= loadCount + 1'b1;
      if (stb.ruleTake && ruleLast) lastTaken <= 1'b1;
      if (stb.capture) pending <= loadCount;
      else if (phase == PH_DRAIN && resTaken) pending <= pending - 1'b1;
      if (phase == PH_DRAIN && phaseNext == PH_LOAD) begin
        loadCount <= '0;
        lastTaken <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rule_match_datapath.sv
module rule_match_datapath
  import rule_match_pkg::*;
#(
  parameter int NUM_PE = 8,
  parameter int NUM_FIELDS = 3,
  parameter int FIELD_W = 8,
  parameter int PRIO_W = 8,
  parameter int ACT_W = 8,
  parameter logic [ACT_W-1:0] DEFAULT_ACTION = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  strobe_t stb,
  input  logic [NUM_FIELDS*FIELD_W-1:0] hdrData,
  input  logic [NUM_FIELDS*FIELD_W-1:0] ruleKey,
  input  logic [NUM_FIELDS-1:0] ruleMask,
  input  logic [PRIO_W-1:0] rulePrio,
  input  logic [ACT_W-1:0] ruleAction,
  input  logic ruleLast,
  output logic topValid,
  output logic resHit,
  output logic [ACT_W-1:0] resAction,
  output logic lastAtEnd
);

  localparam int HDR_W = NUM_FIELDS * FIELD_W;
  localparam int TOP = NUM_PE - 1;

  typedef struct packed {
    logic valid;
    logic last;
    logic [HDR_W-1:0] key;
    logic [NUM_FIELDS-1:0] mask;
    logic [PRIO_W-1:0] prio;
    logic [ACT_W-1:0] action;
  } stage_rule_t;

  logic [HDR_W-1:0] hdrReg [NUM_PE];
  logic [NUM_PE-1:0] occ;
  stage_rule_t ruleReg [NUM_PE];
  logic [NUM_PE-1:0] bestHit;
  logic [ACT_W-1:0] bestAction [NUM_PE];
  logic [NUM_PE-1:0] outValid;
  logic [NUM_PE-1:0] outHit;
  logic [ACT_W-1:0] outAction [NUM_PE];

  // header chain: a new header enters element 0, older ones move up
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      for (int i = 0; i < NUM_PE; i++) hdrReg[i] <= '0;
    end else if (stb.hdrShift) begin
      occ       <= {occ[NUM_PE-2:0], 1'b1};
      hdrReg[0] <= hdrData;
      for (int i = 1; i < NUM_PE; i++) hdrReg[i] <= hdrReg[i-1];
    end else if (stb.capture) begin
      occ <= '0;
    end
  end

  // rule chain: one element per cycle, bubbles where no beat was taken
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PE; i++) ruleReg[i] <= '0;
    end else if (stb.ruleAdvance) begin
      ruleReg[0].valid  <= stb.ruleTake;
      ruleReg[0].last   <= stb.ruleTake && ruleLast;
      ruleReg[0].key    <= ruleKey;
      ruleReg[0].mask   <= ruleMask;
      ruleReg[0].prio   <= rulePrio;
      ruleReg[0].action <= ruleAction;
      for (int i = 1; i < NUM_PE; i++) ruleReg[i] <= ruleReg[i-1];
    end
  end

  assign lastAtEnd = ruleReg[TOP].valid && ruleReg[TOP].last;

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    rule_match_pe #(
      .NUM_FIELDS    (NUM_FIELDS),
      .FIELD_W       (FIELD_W),
      .PRIO_W        (PRIO_W),
      .ACT_W         (ACT_W),
      .DEFAULT_ACTION(DEFAULT_ACTION)
    ) u_pe (
      .clk       (clk),
      .rst_n     (rst_n),
      .clearBest (stb.capture),
      .occupied  (occ[p]),
      .hdr       (hdrReg[p]),
      .ruleValid (ruleReg[p].valid),
      .ruleKey   (ruleReg[p].key),
      .ruleMask  (ruleReg[p].mask),
      .rulePrio  (ruleReg[p].prio),
      .ruleAction(ruleReg[p].action),
      .bestHit   (bestHit[p]),
      .bestAction(bestAction[p])
    );
  end

  // result register: parallel load, serial exit at the top element
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= '0;
      outHit   <= '0;
      for (int i = 0; i < NUM_PE; i++) outAction[i] <= DEFAULT_ACTION;
    end else if (stb.capture) begin
      outValid <= occ;
      outHit   <= bestHit;
      for (int i = 0; i < NUM_PE; i++) outAction[i] <= bestAction[i];
    end else if (stb.outShift) begin
      outValid     <= {outValid[NUM_PE-2:0], 1'b0};
      outHit       <= {outHit[NUM_PE-2:0], 1'b0};
      outAction[0] <= DEFAULT_ACTION;
      for (int i = 1; i < NUM_PE; i++) outAction[i] <= outAction[i-1];
    end
  end

  assign topValid  = outValid[TOP];
  assign resHit    = outHit[TOP];
  assign resAction = outAction[TOP];

endmodule

// File: rtl/rule_match_array.sv
module rule_match_array
  import rule_match_pkg::*;
#(
  parameter int NUM_PE = 8,
  parameter int NUM_FIELDS = 3,
  parameter int FIELD_W = 8,
  parameter int PRIO_W = 8,
  parameter int ACT_W = 8,
  parameter logic [ACT_W-1:0] DEFAULT_ACTION = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hdrValid,
  input  logic [NUM_FIELDS*FIELD_W-1:0] hdrData,
  output logic hdrReady,
  input  logic ruleValid,
  input  logic [NUM_FIELDS*FIELD_W-1:0] ruleKey,
  input  logic [NUM_FIELDS-1:0] ruleMask,
  input  logic [PRIO_W-1:0] rulePrio,
  input  logic [ACT_W-1:0] ruleAction,
  input  logic ruleLast,
  output logic ruleReady,
  output logic resValid,
  output logic resHit,
  output logic [ACT_W-1:0] resAction,
  input  logic resReady
);

  strobe_t stb;
  logic topValid;
  logic lastAtEnd;

  rule_match_ctrl #(.NUM_PE(NUM_PE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdrValid (hdrValid),
    .hdrReady (hdrReady),
    .ruleValid(ruleValid),
    .ruleLast (ruleLast),
    .ruleReady(ruleReady),
    .topValid (topValid),
    .resReady (resReady),
    .lastAtEnd(lastAtEnd),
    .stb      (stb)
  );

  rule_match_datapath #(
    .NUM_PE        (NUM_PE),
    .NUM_FIELDS    (NUM_FIELDS),
    .FIELD_W       (FIELD_W),
    .PRIO_W        (PRIO_W),
    .ACT_W         (ACT_W),
    .DEFAULT_ACTION(DEFAULT_ACTION)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .hdrData   (hdrData),
    .ruleKey   (ruleKey),
    .ruleMask  (ruleMask),
    .rulePrio  (rulePrio),
    .ruleAction(ruleAction),
    .ruleLast  (ruleLast),
    .topValid  (topValid),
    .resHit    (resHit),
    .resAction (resAction),
    .lastAtEnd (lastAtEnd)
  );

  assign resValid = topValid;

endmodule

// File: rtl/rule_match_array_chk.sv
module rule_match_array_chk #(
  parameter int NUM_PE = 8,
  parameter int ACT_W = 8,
  parameter logic [ACT_W-1:0] DEFAULT_ACTION = '0
) (
  input logic clk,
  input logic rst_n,
  input logic hdrValid,
  input logic hdrReady,
  input logic ruleValid,
  input logic ruleReady,
  input logic ruleLast,
  input logic resValid,
  input logic resReady,
  input logic resHit,
  input logic [ACT_W-1:0] resAction
);

  localparam int OUT_W = $clog2(NUM_PE + 1) + 1;

  logic [OUT_W-1:0] outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= '0;
    else outstanding <= outstanding + OUT_W'(hdrValid && hdrReady)
                                    - OUT_W'(resValid && resReady);
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && !resReady |=> resValid && $stable(resHit) && $stable(resAction)); // R8

  AST_NO_RULE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ruleValid && ruleReady && ruleLast |=> !ruleReady); // R6

  AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ruleReady |-> !hdrReady); // R6

  AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && !resHit |-> resAction == DEFAULT_ACTION); // R4

  AST_NO_EXTRA_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> outstanding != '0); // R7

  AST_LOAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hdrReady |-> outstanding < OUT_W'(NUM_PE)); // R5

  AST_NO_RESULT_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    hdrReady |-> !resValid); // R5

endmodule

bind rule_match_array rule_match_array_chk #(
  .NUM_PE        (NUM_PE),
  .ACT_W         (ACT_W),
  .DEFAULT_ACTION(DEFAULT_ACTION)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hdrValid (hdrValid),
  .hdrReady (hdrReady),
  .ruleValid(ruleValid),
  .ruleReady(ruleReady),
  .ruleLast (ruleLast),
  .resValid (resValid),
  .resReady (resReady),
  .resHit   (resHit),
  .resAction(resAction)
);

// File: tb/rule_match_array_test.sv
module rule_match_array_test;

  localparam int CLK_PERIOD = 10;
  localparam int NPE = 8;
  localparam int NF = 2;
  localparam int FW = 4;
  localparam int PW = 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdrValid = 1'b0;
  logic [NF*FW-1:0] hdrData = '0;
  logic hdrReady;
  logic ruleValid = 1'b0;
  logic [NF*FW-1:0] ruleKey = '0;
  logic [NF-1:0] ruleMask = '0;
  logic [PW-1:0] rulePrio = '0;
  logic [AW-1:0] ruleAction = '0;
  logic ruleLast = 1'b0;
  logic ruleReady;
  logic resValid;
  logic resHit;
  logic [AW-1:0] resAction;
  logic resReady = 1'b0;

  int checks = 0;
  int fails = 0;
  int nRules = 0;
  int negCycle = 0;
  logic [7:0] tKey [64];
  logic [1:0] tMask [64];
  logic [3:0] tPrio [64];
  logic [3:0] tAct [64];
  logic [7:0] hd [NPE];

  always #(CLK_PERIOD/2) clk = ~clk;

  rule_match_array #(
    .NUM_PE(NPE), .NUM_FIELDS(NF), .FIELD_W(FW), .PRIO_W(PW), .ACT_W(AW),
    .DEFAULT_ACTION('0)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .hdrValid(hdrValid), .hdrData(hdrData), .hdrReady(hdrReady),
    .ruleValid(ruleValid), .ruleKey(ruleKey), .ruleMask(ruleMask),
    .rulePrio(rulePrio), .ruleAction(ruleAction), .ruleLast(ruleLast),
    .ruleReady(ruleReady),
    .resValid(resValid), .resHit(resHit), .resAction(resAction),
    .resReady(resReady)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // model: strict priority compare, so an earlier rule keeps a tie
  function automatic logic [AW:0] model(input logic [7:0] h);
    logic hit = 1'b0;
    logic [3:0] bp = '0;
    logic [3:0] ba = '0;
    for (int r = 0; r < nRules; r++) begin
      bit ok0 = !tMask[r][0] || (tKey[r][3:0] == h[3:0]);
      bit ok1 = !tMask[r][1] || (tKey[r][7:4] == h[7:4]);
      if (ok0 && ok1 && (!hit || tPrio[r] > bp)) begin
        hit = 1'b1;
        bp  = tPrio[r];
        ba  = tAct[r];
      end
    end
    return {hit, hit ? ba : 4'd0};
  endfunction

  // mode 0 mixed, 1 equal priority, 2 never matches, 3 one wildcard rule
  task automatic buildRules(input int mode, input int n);
    nRules = n;
    for (int r = 0; r < n; r++) begin
      tKey[r]  = {4'((r * 5) % 16), 4'(r % 8)};
      tMask[r] = 2'(r % 4);
      tPrio[r] = 4'((r * 7) % 16);
      tAct[r]  = 4'((r % 15) + 1);
      if (mode == 1) begin
        tPrio[r] = 4'd5;
        tMask[r] = 2'(r % 3);
      end else if (mode == 2) begin
        tMask[r] = 2'b11;
        tKey[r][3:0] = 4'(8 + (r % 8));
      end else if (mode == 3) begin
        tMask[r] = 2'b00;
        tPrio[r] = 4'd9;
        tAct[r]  = 4'd7;
      end
    end
  endtask

  task automatic sendHeaders(input int k, input int b);
    check(ruleReady == 1'b0, "R6 ruleReady during load", ruleReady, 0);
    for (int j = 0; j < k; j++) begin
      hd[j] = {4'((j * 5 + b) % 16), 4'((j + b) % 8)};
      hdrValid = 1'b1;
      hdrData  = hd[j];
      while (!hdrReady) @(negedge clk);
      @(negedge clk);
      hdrValid = 1'b0;
    end
    if (k == NPE) check(hdrReady == 1'b0, "R5 hdrReady when full", hdrReady, 0);
  endtask

  task automatic sendRules(input bit gaps);
    for (int r = 0; r < nRules; r++) begin
      if (gaps && (r % 3 == 1)) begin
        ruleValid = 1'b0;
        @(negedge clk);
      end
      ruleValid  = 1'b1;
      ruleKey    = tKey[r];
      ruleMask   = tMask[r];
      rulePrio   = tPrio[r];
      ruleAction = tAct[r];
      ruleLast   = (r == nRules - 1);
      while (!ruleReady) @(negedge clk);
      @(negedge clk);
      ruleValid = 1'b0;
      ruleLast  = 1'b0;
    end
    check(ruleReady == 1'b0, "R6 ruleReady after last beat", ruleReady, 0);
    check(hdrReady == 1'b0, "R5 hdrReady while rules run", hdrReady, 0);
  endtask

  task automatic collect(input int k, input int readyMode, input string tag);
    bit held = 1'b0;
    logic heldHit = 1'b0;
    logic [AW-1:0] heldAct = '0;
    for (int idx = 0; idx < k; idx++) begin
      logic [AW:0] exp = model(hd[idx]);
      bit done = 1'b0;
      while (!done) begin
        @(negedge clk);
        negCycle++;
        if (held) begin
          check(resValid && resHit == heldHit && resAction == heldAct,
                "R8 stalled result held", {resValid, resHit, resAction}, {1'b1, heldHit, heldAct});
          held = 1'b0;
        end
        case (readyMode)
          0: resReady = 1'b1;
          1: resReady = (negCycle % 3) != 0;
          default: resReady = (negCycle % 4) == 0;
        endcase
        if (resValid && resReady) begin
          check({resHit, resAction} == exp, tag, {resHit, resAction}, exp);
          done = 1'b1;
        end else if (resValid) begin
          held = 1'b1;
          heldHit = resHit;
          heldAct = resAction;
        end
      end
    end
    @(negedge clk);
    resReady = 1'b0;
    check(!resValid && hdrReady, "R7 R10 group closed and load reopened",
          {resValid, hdrReady}, 1);
  endtask

  task automatic runGroup(input int k, input int b, input int mode, input int n,
                          input bit gaps, input int readyMode, input string tag);
    buildRules(mode, n);
    fork
      begin
        sendHeaders(k, b);
        sendRules(gaps);
      end
      collect(k, readyMode, tag);
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(hdrReady == 1'b1, "R5 hdrReady after reset", hdrReady, 1);
    check(ruleReady == 1'b0, "R6 ruleReady after reset", ruleReady, 0);
    check(resValid == 1'b0, "R7 resValid after reset", resValid, 0);

    // R1 R7: every partial load size and a full load
    for (int k = 1; k <= NPE; k++)
      runGroup(k, k, 0, 16, k % 2, k % 3, "R1 R7 mixed ruleset");
    runGroup(NPE, 3, 1, 12, 1'b0, 0, "R3 equal priority");
    runGroup(NPE, 4, 0, 16, 1'b0, 1, "R1 hits before clear");
    runGroup(NPE, 4, 2, 16, 1'b0, 0, "R4 R10 no match after hits");
    runGroup(5, 6, 3, 1, 1'b0, 2, "R2 single wildcard rule");
    runGroup(6, 7, 0, 40, 1'b1, 2, "R9 gapped rule stream");
    runGroup(NPE, 9, 0, 40, 1'b1, 1, "R9 R8 gaps and stalls");

    summary();
    $finish;
  end

endmodule